// File: doc/BRIEF.md
# Bus Write Capture with Expiring Ready Flag

This block sits between a host on a cartridge-style parallel bus and a slower microcontroller. When the host drives a value and pulses its active-low write strobe, the block holds the value in a register and raises a ready flag, so the microcontroller knows a fresh value is waiting.

The flag does not wait for an acknowledge. It expires on its own after a fixed number of host chip-enable pulses, counted by a small timeout counter. The microcontroller therefore has a bounded window in which to read the held value. A new write restarts the window.

Both bus strobes are asynchronous to the block clock. Each passes through a synchronizer, and only its falling edge counts as an event. The block clock must oversample the strobes.

Top module: `bus_write_capture`

## Requirements
- R1: Reset (rst_n low at a rising edge) clears the held data to 0, drops ready to 0 and zeroes the timeout count. After reset, chip-enable pulses alone never raise ready.
- R2: A write is a high-to-low transition of wr_n. Let edge k-2 be the first rising clock edge that samples wr_n low after it was sampled high. At edge k, data_out takes the value data_in had at edge k.
- R3: The same write sets ready to 1 at edge k.
- R4: After a write, ready stays 1 through the first 14 chip-enable pulses. A pulse is a high-to-low transition of ce_n, detected with the same two-edge latency as in R2.
- R5: The 15th chip-enable pulse after a write, which takes the count to 15 (all ones in 4 bits), drops ready to 0 and returns the count to 0.
- R6: A write while ready is 1 replaces data_out and restarts the count at 0. Ready then needs 15 further pulses to drop.
- R7: Chip-enable pulses while ready is 0 leave ready at 0 and leave the count at 0. The next write therefore again needs 15 pulses to expire.
- R8: When a write and a chip-enable pulse are detected in the same cycle, the write wins. Ready is set, the count is 0, and the pulse is not counted.
- R9: Only edges count. Holding wr_n or ce_n low for many cycles gives exactly one event.
- R10: data_out changes only on a write. Changes on data_in at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| ce_n | input | 1 | Host chip enable, active low, asynchronous |
| data_in | input | 7 | Host data bits |
| data_out | output | 7 | Held data for the microcontroller |
| ready | output | 1 | New data waiting; expires after 15 chip-enable pulses |

## Verification
The assertions take three things for granted about the inputs:
- data_in is stable from before wr_n falls until the capture edge, two edges after the fall is first sampled;
- each strobe level lasts at least two clock cycles, so no edge is lost in the synchronizer;
- the counted events are the synchronized falling edges.

The stimulus meets these conditions in every case:
- inputs change only at falling clock edges;
- data is set together with the strobe fall and held until after the capture edge;
- every strobe low and high phase lasts three clock cycles or more.

Simultaneous strobe falls are driven on purpose to test write priority.

// File: rtl/wcap_pkg.sv
// Package: shared defaults and the event bundle passed from the strobe
// synchronizers to the capture and timeout logic.
package wcap_pkg;
    localparam int DEF_DATA_W = 7;
    localparam int DEF_CNT_W  = 4;
    localparam int DEF_SYNC   = 2;

    // One-cycle events decoded from the bus strobes.
    typedef struct packed {
        logic ce;   // chip-enable falling edge seen
        logic wr;   // write strobe falling edge seen
    } wcap_evt_t;
endpackage

// File: rtl/wcap_fall_det.sv
// Module: wcap_fall_det
// Brings an asynchronous active-low strobe into the clock domain through
// STAGES flops. It emits a one-cycle pulse when the synchronized level goes
// from high to low.
// Assumes: each strobe level lasts at least two clock cycles. Reset parks
// the chain at the idle (high) level.
module wcap_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    // Shift the raw strobe through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[LAST-1:0], line_n};
    end

    // Falling edge: older sample high, newer sample low.
    always_comb begin
        fall = chain_q[LAST] & ~chain_q[LAST-1];
    end

    // Edges only: an event can never repeat on the next cycle.
    p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/wcap_data_hold.sv
// Module: wcap_data_hold
// Register that holds the host data. It loads on a write event and keeps its
// value otherwise.
// Assumes: data_in is stable in the cycle the write event is decoded.
module wcap_data_hold #(
    parameter int DATA_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_q
);
    // Capture on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= data_in;
    end

    // The value present at the write event is what gets held.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> data_q == $past(data_in));

    // Without a write the held value does not move.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(data_q));
endmodule

// File: rtl/wcap_timeout.sv
// Module: wcap_timeout
// Ready flag with an expiry counter.
// - A write sets the flag and zeroes the count.
// - Each chip-enable event while the flag is set advances the count.
// - Reaching the all-ones count drops the flag and returns the count to zero.
// Assumes: a write and a chip-enable event in one cycle resolve to the write.
module wcap_timeout #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  wcap_pkg::wcap_evt_t evt,
    output logic ready
);
    localparam logic [CNT_W-1:0] TERM      = '1;
    localparam logic [CNT_W-1:0] PRE_TERM  = TERM - 1'b1;

    logic [CNT_W-1:0] cnt_q;
    logic             rdy_q;
    logic             expire;

    // Decode the event that would take the count to terminal.
    always_comb begin
        expire = rdy_q && evt.ce && !evt.wr && (cnt_q == PRE_TERM);
    end

    // Flag and counter update, with write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
            cnt_q <= '0;
        end else if (evt.wr) begin
            rdy_q <= 1'b1;
            cnt_q <= '0;
        end else if (expire) begin
            rdy_q <= 1'b0;
            cnt_q <= '0;
        end else if (rdy_q && evt.ce) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready = rdy_q;

    // A write always yields ready with a fresh count (R3, R6, R8).
    p_write_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt.wr |=> rdy_q && cnt_q == '0);

    // Terminal pulse drops the flag.
    p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q && evt.ce && !evt.wr && cnt_q == PRE_TERM) |=> !rdy_q && cnt_q == '0);

    // Earlier pulses advance by one and keep the flag.
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q && evt.ce && !evt.wr && cnt_q != PRE_TERM)
            |=> rdy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // Idle counter parks at zero.
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_q |-> cnt_q == '0);
endmodule

// File: rtl/bus_write_capture.sv
// Module: bus_write_capture
// Top level. Synchronizes the two bus strobes and turns their falling edges
// into events. Those events drive the data register and the expiring ready
// flag.
// Assumes: clk oversamples both strobes. Data is stable through the capture
// edge.
module bus_write_capture #(
    parameter int DATA_W = wcap_pkg::DEF_DATA_W,
    parameter int CNT_W  = wcap_pkg::DEF_CNT_W,
    parameter int SYNC   = wcap_pkg::DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              ce_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              ready
);
    localparam int N_STROBE = 2;

    logic [N_STROBE-1:0] strobe_n;
    logic [N_STROBE-1:0] strobe_fall;
    wcap_pkg::wcap_evt_t evt;

    // Gather the strobes so one generate loop builds both detectors.
    always_comb begin
        strobe_n = {ce_n, wr_n};
    end

    for (genvar g = 0; g < N_STROBE; g++) begin : g_det
        wcap_fall_det #(.STAGES(SYNC)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_n (strobe_n[g]),
            .fall   (strobe_fall[g])
        );
    end

    // Name the events for the downstream logic.
    always_comb begin
        evt.wr = strobe_fall[0];
        evt.ce = strobe_fall[1];
    end

    wcap_data_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (evt.wr),
        .data_in (data_in),
        .data_q  (data_out)
    );

    wcap_timeout #(.CNT_W(CNT_W)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .ready (ready)
    );

    // A write shows up on both outputs together (R2, R3).
    p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt.wr |=> ready && data_out == $past(data_in));
endmodule

// File: tb/bus_write_capture_bench.sv
// Bench: reference model compared every cycle, plus directed checks per
// requirement.
module bus_write_capture_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1;
    logic       ce_n = 1'b1;
    logic [6:0] data_in = '0;
    logic [6:0] data_out;
    logic       ready;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_write_capture u_bus_write_capture (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .ce_n(ce_n),
        .data_in(data_in), .data_out(data_out), .ready(ready)
    );

    // Behavioural reference: sample history and event rules from the requirements.
    int  w1 = 1, w2 = 1, w3 = 1, c1 = 1, c2 = 1, c3 = 1;
    int  m_cnt = 0;
    bit  m_rdy = 0;
    logic [6:0] m_dat = '0;

    always @(posedge clk) begin
        bit wev, cev;
        if (!rst_n) begin
            w1 = 1; w2 = 1; w3 = 1; c1 = 1; c2 = 1; c3 = 1;
            m_cnt = 0; m_rdy = 0; m_dat = '0;
        end else begin
            wev = (w3 == 1) && (w2 == 0);
            cev = (c3 == 1) && (c2 == 0);
            if (wev) begin
                m_dat = data_in; m_rdy = 1; m_cnt = 0;
            end else if (cev && m_rdy) begin
                if (m_cnt == 14) begin m_rdy = 0; m_cnt = 0; end
                else m_cnt++;
            end
            w3 = w2; w2 = w1; w1 = wr_n;
            c3 = c2; c2 = c1; c1 = ce_n;
        end
    end

    // Compare against the model every cycle (R2/R3 data and flag tracking).
    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (data_out !== m_dat || ready !== m_rdy) begin
                bad++;
                $display("FAIL R2 model: actual data=%0h ready=%0b expected data=%0h ready=%0b",
                         data_out, ready, m_dat, m_rdy);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] d, input int low_cyc);
        @(negedge clk); data_in = d; wr_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic ce_pulse(input int low_cyc);
        @(negedge clk); ce_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) ce_pulse(3);
    endtask

    task automatic finish_run;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset data", {25'd0, data_out}, 32'h0);
        chk("R1 reset ready", {31'd0, ready}, 32'h0);
        rst_n = 1'b1;
        pulses(3);
        chk("R1 pulses after reset", {31'd0, ready}, 32'h0);

        // R2 exact latency: data appears at edge k, where edge k-2 first saw the strobe low.
        @(negedge clk); data_in = 7'h55; wr_n = 1'b0;
        @(negedge clk); chk("R2 not yet (1)", {31'd0, ready}, 32'h0);
        @(negedge clk); chk("R2 not yet (2)", {31'd0, ready}, 32'h0);
        @(negedge clk); chk("R2 capture", {25'd0, data_out}, 32'h55);
        chk("R3 ready set", {31'd0, ready}, 32'h1);
        wr_n = 1'b1; repeat (4) @(negedge clk);

        data_in = 7'h2A; repeat (6) @(negedge clk);
        chk("R10 data ignored", {25'd0, data_out}, 32'h55);

        pulses(14);
        chk("R4 ready after 14", {31'd0, ready}, 32'h1);
        pulses(1);
        chk("R5 ready after 15", {31'd0, ready}, 32'h0);
        chk("R5 data kept", {25'd0, data_out}, 32'h55);

        pulses(5);
        chk("R7 idle pulses", {31'd0, ready}, 32'h0);
        do_write(7'h11, 3);
        pulses(14);
        chk("R7 count parked at zero", {31'd0, ready}, 32'h1);
        pulses(1);
        chk("R7 expiry after 15", {31'd0, ready}, 32'h0);

        do_write(7'h33, 3);
        pulses(10);
        do_write(7'h44, 3);
        chk("R6 overwrite data", {25'd0, data_out}, 32'h44);
        pulses(14);
        chk("R6 restart 14", {31'd0, ready}, 32'h1);
        pulses(1);
        chk("R6 restart 15", {31'd0, ready}, 32'h0);

        do_write(7'h0F, 40);
        chk("R9 long write", {25'd0, data_out}, 32'h0F);
        ce_pulse(40);
        pulses(13);
        chk("R9 long ce counts once", {31'd0, ready}, 32'h1);
        pulses(1);
        chk("R9 expiry", {31'd0, ready}, 32'h0);

        do_write(7'h0A, 3);
        pulses(5);
        @(negedge clk); data_in = 7'h7F; wr_n = 1'b0; ce_n = 1'b0;
        repeat (3) @(negedge clk); wr_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 write wins data", {25'd0, data_out}, 32'h7F);
        pulses(14);
        chk("R8 count from zero", {31'd0, ready}, 32'h1);
        pulses(1);
        chk("R8 expiry", {31'd0, ready}, 32'h0);

        do_write(7'h66, 3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset data", {25'd0, data_out}, 32'h0);
        chk("R1 mid reset ready", {31'd0, ready}, 32'h0);
        rst_n = 1'b1;
        pulses(2);
        chk("R1 stays idle", {31'd0, ready}, 32'h0);

        finish_run();
    end
endmodule